// File: doc/BRIEF.md
# Serial ADC Host Controller

This block sits in a system-clock domain and runs a 16-bit successive-approximation converter over a three-wire serial link that has an extra configuration input. A one-cycle start request begins a transaction. The host makes a fresh rising edge on the convert line and holds that line high for the conversion window. It then drops the line and produces sixteen shift-clock periods. During those periods it shifts out a two-bit multiplexer word and captures the sixteen result bits.

The multiplexer word sent during a transaction selects the input for the conversion that follows, not for the result being read. The host therefore keeps track of which configuration was actually in force for each sample. It reports that configuration next to the result and raises a one-cycle valid pulse. Between transactions the convert line stays high, which lets the converter sleep.

Top module: `sar_adc_host`

## Requirements
- R1: After reset and between transactions, `cvt_o` is 1, `sclk_o` is 0, `cfg_bit_o` is 0 and `busy_o` is 0. A reset in the middle of a transaction returns the block to this state, and `data_o` reads 0 after reset.
- R2: After a start in idle, `cvt_o` goes low for exactly one system clock. It then stays high for exactly `CONV_CYCLES` system clocks before it falls for the transfer.
- R3: During the transfer `sclk_o` runs exactly 16 periods. Each period is `HALF_DIV` system clocks low followed by `HALF_DIV` high, and the first rising edge comes `HALF_DIV` clocks after `cvt_o` falls. `sclk_o` is 0 whenever `cvt_o` is high.
- R4: `adc_dat_i` is sampled at each rising edge of `sclk_o`. The first sample becomes bit 15 of `data_o` and the last becomes bit 0.
- R5: `cfg_bit_o` presents `cfg_i[1]` (1 = input against ground, 0 = differential pair) before the first rising clock edge and `cfg_i[0]` (channel / polarity select) before the second. It is 0 at every later rising edge. Codes: 10 = ch0 against ground, 11 = ch1 against ground, 00 = ch0 positive / ch1 negative, 01 = ch1 positive / ch0 negative.
- R6: `cfg_o` reports the code sent in the previous transaction, because that code set up the sample just read. For the first transaction after reset it reports 2'b10.
- R7: `valid_o` is high for exactly one cycle, in the first idle cycle after the transfer, with `cvt_o` already high. `data_o` and `cfg_o` hold their values until the next valid pulse.
- R8: `start_i` is ignored while `busy_o` is 1: the code it carries is not sent and it adds no transaction. The block never leaves idle without `start_i`.
- R9: `cvt_o` rises exactly `HALF_DIV` system clocks after the last rising edge of `sclk_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, sampled while idle |
| cfg_i | input | 2 | Multiplexer code to send (bit 1 sent first) |
| adc_dat_i | input | 1 | Serial result bit from the converter |
| cvt_o | output | 1 | Convert line to the converter |
| sclk_o | output | 1 | Shift clock to the converter |
| cfg_bit_o | output | 1 | Serial multiplexer bit to the converter |
| busy_o | output | 1 | Transaction in progress |
| valid_o | output | 1 | One-cycle result strobe |
| data_o | output | 16 | Result, unsigned, first bit received is the MSB |
| cfg_o | output | 2 | Multiplexer code that applied to `data_o` |

## Verification
The bench builds the block with `HALF_DIV` = 3 and `CONV_CYCLES` = 40. This keeps the shift clock at its real speed and 50% duty, so setup and hold relations between the convert line and the clock edges are seen exactly as on silicon. The conversion window is shortened so that dozens of transactions, a reset during a transfer and an ignored mid-transaction start all fit in a short run. The converter model in the bench latches a code at each rising convert edge and shifts it out on falling clock edges. It also decodes the multiplexer word it receives, which lets the bench check the one-transaction lag of the channel code at the ports.

// File: rtl/sar_host_pkg.sv
package sar_host_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACQ  = 2'd1,
    ST_CONV = 2'd2,
    ST_XFER = 2'd3
  } host_state_e;
endpackage

// File: rtl/sar_sclk_gen.sv
module sar_sclk_gen #(
  parameter int HALF_DIV = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic sclk_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CW = $clog2(HALF_DIV) + 1;

  logic [CW-1:0] cnt_q;
  logic          lvl_q;
  logic          wrap;

  assign wrap   = en_i && (cnt_q == CW'(HALF_DIV - 1));
  assign rise_o = wrap && !lvl_q;
  assign fall_o = wrap && lvl_q;
  assign sclk_o = lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      lvl_q <= !lvl_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/sar_shifter.sv
module sar_shifter #(
  parameter int DATA_W = 16,
  parameter int CFG_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [CFG_W-1:0]  cfg_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              dat_i,
  output logic              cfg_bit_o,
  output logic [DATA_W-1:0] rx_o
);
  logic [CFG_W-1:0]  tx_q;
  logic [DATA_W-1:0] rx_q;

  assign cfg_bit_o = tx_q[CFG_W-1];
  assign rx_o      = rx_q;

  // tx advances on falling clock so each bit is stable across the next rise
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     tx_q <= '0;
    else if (load_i) tx_q <= cfg_i;
    else if (fall_i) tx_q <= {tx_q[CFG_W-2:0], 1'b0};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rx_q <= '0;
    else if (rise_i) rx_q <= {rx_q[DATA_W-2:0], dat_i};
  end
endmodule

// File: rtl/sar_adc_host.sv
module sar_adc_host
  import sar_host_pkg::*;
#(
  parameter int          DATA_W      = 16,
  parameter int          CFG_W       = 2,
  parameter int          HALF_DIV    = 3,
  parameter int          CONV_CYCLES = 320,
  parameter logic [1:0]  CFG_RESET   = 2'b10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CFG_W-1:0]  cfg_i,
  input  logic              adc_dat_i,
  output logic              cvt_o,
  output logic              sclk_o,
  output logic              cfg_bit_o,
  output logic              busy_o,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic [CFG_W-1:0]  cfg_o
);
  localparam int TW = $clog2(CONV_CYCLES + 1);
  localparam int BW = $clog2(DATA_W + 1);

  host_state_e       state_q, state_d;
  logic [TW-1:0]     tmr_q;
  logic [BW-1:0]     bits_q;
  logic [CFG_W-1:0]  pend_q, act_q, cfg_q;
  logic [DATA_W-1:0] data_q, rx;
  logic              cvt_q, valid_q;
  logic              rise, fall, take, done;

  assign take = (state_q == ST_IDLE) && start_i;
  assign done = (state_q == ST_XFER) && fall && (bits_q == BW'(DATA_W));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_ACQ;
      ST_ACQ:  state_d = ST_CONV;
      ST_CONV: if (tmr_q == TW'(CONV_CYCLES - 1)) state_d = ST_XFER;
      ST_XFER: if (done) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cvt_q   <= 1'b1;
      tmr_q   <= '0;
      bits_q  <= '0;
    end else begin
      state_q <= state_d;
      cvt_q   <= (state_d == ST_IDLE) || (state_d == ST_CONV);
      tmr_q   <= (state_q == ST_CONV) ? tmr_q + 1'b1 : '0;
      if (state_q != ST_XFER) bits_q <= '0;
      else if (rise)          bits_q <= bits_q + 1'b1;
    end
  end

  // the code sent now governs the next sample; report the one in force
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= '0;
      act_q   <= CFG_RESET;
      cfg_q   <= '0;
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= done;
      if (take) pend_q <= cfg_i;
      if (done) begin
        data_q <= rx;
        cfg_q  <= act_q;
        act_q  <= pend_q;
      end
    end
  end

  sar_sclk_gen #(.HALF_DIV(HALF_DIV)) u_sclk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (state_q == ST_XFER),
    .sclk_o (sclk_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  sar_shifter #(.DATA_W(DATA_W), .CFG_W(CFG_W)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (take),
    .cfg_i     (cfg_i),
    .rise_i    (rise),
    .fall_i    (fall),
    .dat_i     (adc_dat_i),
    .cfg_bit_o (cfg_bit_o),
    .rx_o      (rx)
  );

  assign cvt_o   = cvt_q;
  assign busy_o  = (state_q != ST_IDLE);
  assign valid_o = valid_q;
  assign data_o  = data_q;
  assign cfg_o   = cfg_q;
endmodule

// File: rtl/sar_adc_host_chk.sv
module sar_adc_host_chk #(
  parameter int CONV_CYCLES = 320
) (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic busy_o,
  input logic cvt_o,
  input logic sclk_o,
  input logic cfg_bit_o,
  input logic valid_o
);
  logic [31:0] hi_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hi_cnt <= '0;
    else if (!busy_o) hi_cnt <= '0;
    else if (cvt_o)   hi_cnt <= hi_cnt + 1;
  end

  assert_idle_lines_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> cvt_o && !sclk_o && !cfg_bit_o);

  assert_conv_window_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $fell(cvt_o) && $past(busy_o) |-> hi_cnt == 32'(CONV_CYCLES));

  assert_sclk_low_conv_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cvt_o |-> !sclk_o);

  assert_valid_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  assert_valid_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !busy_o && cvt_o);

  assert_no_self_start_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !start_i |=> !busy_o);
endmodule

bind sar_adc_host sar_adc_host_chk #(.CONV_CYCLES(CONV_CYCLES)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .busy_o    (busy_o),
  .cvt_o     (cvt_o),
  .sclk_o    (sclk_o),
  .cfg_bit_o (cfg_bit_o),
  .valid_o   (valid_o)
);

// File: tb/sar_adc_host_bench.sv
`timescale 1ns/1ps
module sar_adc_host_bench;
  localparam int HALF = 3;
  localparam int CONV = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  cfg_i = 2'b00;
  logic        adc_dat;
  logic        cvt, sclk, cfg_bit, busy, valid;
  logic [15:0] data;
  logic [1:0]  cfg_out;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = !clk;

  sar_adc_host #(.HALF_DIV(HALF), .CONV_CYCLES(CONV)) u_sar_adc_host (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .cfg_i(cfg_i),
    .adc_dat_i(adc_dat), .cvt_o(cvt), .sclk_o(sclk), .cfg_bit_o(cfg_bit),
    .busy_o(busy), .valid_o(valid), .data_o(data), .cfg_o(cfg_out)
  );

  // converter model
  logic [15:0] next_code = 16'h0000;
  logic [15:0] conv_code = 16'h0000;
  logic [15:0] sh = 16'h0000;
  logic [1:0]  mux_cfg = 2'b00;
  logic        mux_hi = 1'b0;
  logic        last_sclk = 1'b0;
  int          rx_cnt = 0;
  int          extra_ones = 0;

  always @(posedge cvt) conv_code <= next_code;

  always @(negedge cvt or posedge sclk or negedge sclk) begin
    if (sclk != last_sclk) begin
      if (sclk) begin
        if (rx_cnt == 0) mux_hi <= cfg_bit;
        else if (rx_cnt == 1) mux_cfg <= {mux_hi, cfg_bit};
        else if (cfg_bit) extra_ones <= extra_ones + 1;
        rx_cnt <= rx_cnt + 1;
      end else begin
        adc_dat <= sh[15];
        sh <= sh << 1;
      end
      last_sclk <= sclk;
    end else begin
      adc_dat <= conv_code[15];
      sh <= conv_code << 1;
      rx_cnt <= 0;
    end
  end

  // port timing monitor
  logic p_cvt = 1'b1, p_sclk = 1'b0, p_busy = 1'b0;
  int lo_cnt = 0, hi_cnt = 0, run = 0;
  int acq_len = 0, conv_len = 0, hold_len = 0, rises = 0, sclk_bad = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (cvt && !p_cvt && busy) begin acq_len = lo_cnt; rises = 0; end
      if (cvt && !p_cvt && !busy && p_sclk) hold_len = run;
      if (!cvt && p_cvt && busy && p_busy) conv_len = hi_cnt;
      if (!cvt) lo_cnt = p_cvt ? 1 : lo_cnt + 1;
      if (cvt && busy) hi_cnt = (p_cvt && p_busy) ? hi_cnt + 1 : 1;
      if (cvt) run = 0;
      else if (sclk == p_sclk) run = run + 1;
      else begin
        if (run != HALF) sclk_bad = sclk_bad + 1;
        if (sclk) rises = rises + 1;
        run = 1;
      end
    end
    p_cvt = cvt; p_sclk = sclk; p_busy = busy;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  logic [1:0] exp_cfg = 2'b10;

  task automatic start_txn(input logic [1:0] c, input logic [15:0] code);
    next_code = code;
    @(negedge clk); start_i = 1'b1; cfg_i = c;
    @(negedge clk); start_i = 1'b0;
  endtask

  task automatic finish_txn(input logic [1:0] c, input logic [15:0] code);
    bit got = 0;
    for (int k = 0; k < 2000 && !got; k++) begin
      @(negedge clk);
      if (valid) got = 1;
    end
    check(got, "R7 valid seen", int'(got), 1);
    if (got) begin
      check(data == code, "R4 data", int'(data), int'(code));
      check(cfg_out == exp_cfg, "R6 cfg lag", int'(cfg_out), int'(exp_cfg));
      @(negedge clk);
      check(!valid && data == code, "R7 pulse/hold", int'({valid, data}), int'(code));
      check(mux_cfg == c, "R5 mux word", int'(mux_cfg), int'(c));
      check(extra_ones == 0, "R5 trailing zeros", extra_ones, 0);
      check(acq_len == 1, "R2 acquire low", acq_len, 1);
      check(conv_len == CONV, "R2 convert high", conv_len, CONV);
      check(rises == 16, "R3 clock count", rises, 16);
      check(sclk_bad == 0, "R3 half periods", sclk_bad, 0);
      check(hold_len == HALF, "R9 hold", hold_len, HALF);
      exp_cfg = c;
    end
  endtask

  localparam logic [17:0] VEC [8] = '{
    {2'b10, 16'h0000}, {2'b11, 16'hFFFF}, {2'b00, 16'h8001},
    {2'b01, 16'h7FFE}, {2'b10, 16'hA5C3}, {2'b00, 16'h1234},
    {2'b11, 16'h0001}, {2'b01, 16'h8000}
  };

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(cvt && !sclk && !cfg_bit && !busy && !valid, "R1 reset idle",
          int'({cvt, sclk, cfg_bit, busy, valid}), 5'b10000);
    check(data == 16'h0 && cfg_out == 2'b00, "R1 reset data", int'(data), 0);

    for (int i = 0; i < 8; i++) begin
      start_txn(VEC[i][17:16], VEC[i][15:0]);
      finish_txn(VEC[i][17:16], VEC[i][15:0]);
      check(cvt && !busy && !sclk && !cfg_bit, "R1 between txns", int'({cvt, busy}), 2'b10);
    end

    // start during a transaction is ignored
    start_txn(2'b11, 16'h3C3C);
    repeat (20) @(negedge clk);
    start_i = 1'b1; cfg_i = 2'b00;
    @(negedge clk); start_i = 1'b0;
    finish_txn(2'b11, 16'h3C3C);
    begin
      int extra = 0;
      for (int k = 0; k < 300; k++) begin
        @(negedge clk);
        if (valid || busy) extra++;
      end
      check(extra == 0, "R8 no extra txn", extra, 0);
    end
    start_txn(2'b01, 16'h5A5A);
    finish_txn(2'b01, 16'h5A5A);

    // reset during transfer
    start_txn(2'b00, 16'hBEEF);
    repeat (70) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(cvt && !sclk && !cfg_bit && !busy && !valid, "R1 mid reset",
          int'({cvt, sclk, cfg_bit, busy, valid}), 5'b10000);
    rst_n = 1'b1;
    exp_cfg = 2'b10;
    @(negedge clk);
    start_txn(2'b11, 16'hC0DE);
    finish_txn(2'b11, 16'hC0DE);
    start_txn(2'b10, 16'h0F0F);
    finish_txn(2'b10, 16'h0F0F);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule